// File: doc/BRIEF.md
# Triggered Circular Capture Controller

This block records a stream of 8-bit samples into a circular dual-port buffer around a trigger event, in the manner of a digital storage oscilloscope's acquisition engine. The host first programs a trigger polarity and a threshold level. The block then fills the buffer continuously. Once it has enough history, it looks for a threshold crossing of the chosen polarity. After the trigger it stores half a buffer more of samples and freezes, so that the trigger sample sits in the middle of the record.

Completion crosses into the host clock domain as a ready flag. The host reads the record at its own pace through a separate address port. Each read is counted, and when a full buffer's worth has been read the block re-arms itself with the same settings. The sample side and the read side share no per-sample handshake. Only the ready and drained status flags cross between the two clocks, each through a two-flop synchroniser.

Top module: `scope_capture`

## Requirements
- R1: After reset `hst_ready` is low and `trig_addr` is zero.
- R2: With `cfg_rising`=1 the trigger fires on the first eligible valid sample that is at or above `cfg_level` while the previous valid sample was below it. A previous sample equal to the level does not qualify.
- R3: With `cfg_rising`=0 the trigger fires on the first eligible valid sample below the level while the previous valid sample was at or above it, including equal to it.
- R4: A crossing is ignored unless at least DEPTH/2 valid samples were written since arming, before the crossing sample itself.
- R5: After the trigger sample, exactly DEPTH/2 more valid samples are stored (samples with `smp_vld` low are neither stored nor counted), and `hst_ready` stays low until the last of them has arrived.
- R6: `trig_addr` is the buffer address of the trigger sample. The record occupies addresses `trig_addr-(DEPTH/2-1)` up to `trig_addr+DEPTH/2` (modulo DEPTH) in arrival order. Pulsing `hst_rd` with `hst_addr` returns that word on `hst_data` after the next `hst_clk` edge. Write addresses continue circularly across acquisitions.
- R7: Samples that arrive after the record is complete are not written, and the record read back is unchanged.
- R8: `hst_ready` rises in the host domain after completion and stays high through DEPTH-1 reads. It falls in the cycle after the DEPTH-th read issued while it is high.
- R9: Once the record is drained, the block re-arms by itself with the same configuration and captures the next record.
- R10: A `cfg_we` pulse loads the polarity and level, discards any record in progress or held, drops `hst_ready`, and restarts arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sample clock |
| hst_clk | input | 1 | Host read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| smp_vld | input | 1 | Sample present this smp_clk cycle |
| smp_data | input | DW | Sample value |
| cfg_we | input | 1 | Configuration write strobe (smp_clk domain) |
| cfg_rising | input | 1 | 1: rising-crossing trigger, 0: falling |
| cfg_level | input | DW | Trigger threshold |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | AW | Host read address |
| hst_data | output | DW | Read data, one hst_clk after the strobe |
| hst_ready | output | 1 | Record complete and not yet drained (hst_clk domain) |
| trig_addr | output | AW | Buffer address of the trigger sample |

## Verification
The situations hardest to reach from the ports are the eligibility boundary and the equality cases of the crossing test. The bench builds sample sequences arithmetically with a decoy crossing placed before eligibility (up to the very last ineligible index) and the real crossing at positions from the earliest legal index onward, for both polarities and for thresholds at the ends and middle of the range. A configuration write is also forced while a record is half-built and again while a full record is waiting for the host, and the next capture is checked to start cleanly from fresh history.

// File: rtl/scope_capture.sv
module scope_capture #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          smp_clk,
  input  logic          hst_clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic          cfg_we,
  input  logic          cfg_rising,
  input  logic [DW-1:0] cfg_level,
  input  logic          hst_rd,
  input  logic [AW-1:0] hst_addr,
  output logic [DW-1:0] hst_data,
  output logic          hst_ready,
  output logic [AW-1:0] trig_addr
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] HLAST = AW'(DEPTH / 2 - 1);

  typedef enum logic [1:0] {FILL = 2'd0, HUNT = 2'd1, POST = 2'd2, HOLD = 2'd3} st_t;

  logic [DW-1:0] mem [DEPTH];
  st_t           st;
  logic [AW-1:0] cnt, wptr, rcnt;
  logic [DW-1:0] prev, lvl;
  logic          rising, drained;
  logic [1:0]    rdy_q, drn_q;
  logic          we, hit, full, drn_s;

  assign full  = (st == HOLD);
  assign drn_s = drn_q[1];
  assign we    = smp_vld && !full && !cfg_we;
  assign hit   = rising ? (prev <  lvl && smp_data >= lvl)
                        : (prev >= lvl && smp_data <  lvl);

  always_ff @(posedge smp_clk)
    if (we) mem[wptr] <= smp_data;

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n) begin
      st <= FILL;
      cnt <= '0;
      wptr <= '0;
      prev <= '0;
      lvl <= '0;
      rising <= 1'b1;
      trig_addr <= '0;
      drn_q <= '0;
    end else begin
      drn_q <= {drn_q[0], drained};
      if (we) begin
        wptr <= wptr + 1'b1;
        prev <= smp_data;
      end
      if (cfg_we) begin
        lvl <= cfg_level;
        rising <= cfg_rising;
        st <= FILL;
        cnt <= '0;
      end else begin
        case (st)
          FILL:
            if (smp_vld) begin
              if (cnt != HLAST) cnt <= cnt + 1'b1;
              else if (!drn_s) st <= HUNT;
            end
          HUNT:
            if (smp_vld && hit) begin
              st <= POST;
              trig_addr <= wptr;
              cnt <= '0;
            end
          POST:
            if (smp_vld) begin
              if (cnt == HLAST) st <= HOLD;
              cnt <= cnt + 1'b1;
            end
          HOLD:
            if (drn_s) begin
              st <= FILL;
              cnt <= '0;
            end
          default: st <= FILL;
        endcase
      end
    end

  always_ff @(posedge hst_clk or negedge rst_n)
    if (!rst_n) begin
      rdy_q <= '0;
      drained <= 1'b0;
      rcnt <= '0;
    end else begin
      rdy_q <= {rdy_q[0], full};
      if (!rdy_q[1]) begin
        drained <= 1'b0;
        rcnt <= '0;
      end else if (hst_rd && !drained) begin
        rcnt <= rcnt + 1'b1;
        if (rcnt == '1) drained <= 1'b1;
      end
    end

  always_ff @(posedge hst_clk)
    if (hst_rd) hst_data <= mem[hst_addr];

  assign hst_ready = rdy_q[1] && !drained;
endmodule

module scope_capture_chk #(
  parameter int AW = 12
) (
  input logic          smp_clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    st,
  input logic [AW-1:0] cnt,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] trig_addr
);
  localparam logic [AW-1:0] HLAST = AW'((1 << AW) / 2 - 1);
  localparam logic [1:0] S_FILL = 2'd0, S_HUNT = 2'd1, S_POST = 2'd2, S_HOLD = 2'd3;

  a_r4_hunt_after_fill: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (st == S_HUNT && $past(st) == S_FILL) |-> $past(cnt) == HLAST);

  a_r5_post_length: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (st == S_HOLD && $past(st) == S_POST) |-> $past(cnt) == HLAST);

  a_r7_hold_frozen: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (st == S_HOLD && !cfg_we) |=> $stable(wptr));

  a_r6_trig_stable: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (st != S_HUNT && !cfg_we) |=> $stable(trig_addr));

  a_r10_cfg_rearm: assert property (@(posedge smp_clk) disable iff (!rst_n)
    cfg_we |=> (st == S_FILL && cnt == '0));
endmodule

bind scope_capture scope_capture_chk #(.AW(AW)) u_chk (
  .smp_clk(smp_clk),
  .rst_n(rst_n),
  .cfg_we(cfg_we),
  .st(st),
  .cnt(cnt),
  .wptr(wptr),
  .trig_addr(trig_addr)
);

// File: tb/sim_scope_capture.sv
module sim_scope_capture;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = DEPTH / 2;

  logic smp_clk = 0, hst_clk = 0, rst_n = 0;
  logic smp_vld = 0, cfg_we = 0, cfg_rising = 1, hst_rd = 0;
  logic [7:0] smp_data = 0, cfg_level = 0;
  logic [AW-1:0] hst_addr = 0;
  logic [7:0] hst_data;
  logic hst_ready;
  logic [AW-1:0] trig_addr;

  always #5 smp_clk = ~smp_clk;
  always #13 hst_clk = ~hst_clk;

  scope_capture #(.AW(AW), .DW(8)) u0 (
    .smp_clk(smp_clk), .hst_clk(hst_clk), .rst_n(rst_n),
    .smp_vld(smp_vld), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_rising(cfg_rising), .cfg_level(cfg_level),
    .hst_rd(hst_rd), .hst_addr(hst_addr), .hst_data(hst_data),
    .hst_ready(hst_ready), .trig_addr(trig_addr)
  );

  int n_chk = 0, n_bad = 0, wc = 0, gapc = 0;
  logic [7:0] seq [64];

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit hit(bit rise, logic [7:0] p, logic [7:0] c, logic [7:0] l);
    return rise ? (p < l && c >= l) : (p >= l && c < l);
  endfunction

  task automatic build(bit rise, int l, int k, int d);
    for (int i = 0; i < 64; i++) begin
      if (i > k) seq[i] = 8'((i * 37 + 11) % 256);
      else if (rise) seq[i] = (i < k) ? 8'((i * 7 + 3) % l) : 8'(l + (k * 5) % (256 - l));
      else seq[i] = (i < k) ? 8'(l + (i * 7 + 3) % (256 - l)) : 8'((k * 5) % l);
    end
    seq[d] = rise ? 8'(l) : 8'(l - 1);
  endtask

  function automatic int scan(bit rise, logic [7:0] l);
    for (int j = HALF; j < 64; j++)
      if (hit(rise, seq[j-1], seq[j], l)) return j;
    return 63;
  endfunction

  task automatic send(logic [7:0] v, bit counted);
    @(negedge smp_clk);
    if (gapc % 4 == 3) @(negedge smp_clk);
    gapc++;
    smp_vld = 1;
    smp_data = v;
    @(posedge smp_clk);
    #1 smp_vld = 0;
    if (counted) wc++;
  endtask

  task automatic cfg(bit rise, logic [7:0] l);
    @(negedge smp_clk);
    cfg_we = 1; cfg_rising = rise; cfg_level = l;
    @(negedge smp_clk);
    cfg_we = 0;
  endtask

  task automatic wait_ready(bit want);
    for (int i = 0; i < 20; i++) begin
      @(negedge hst_clk);
      if (hst_ready == want) break;
    end
  endtask

  task automatic drain(logic [AW-1:0] ta, int ke);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge hst_clk);
      if (i > 0) chk(hst_data, seq[ke - (HALF - 1) + i - 1], "R6 R7 record word");
      if (i == DEPTH - 1) chk(hst_ready, 1, "R8 ready before last read");
      hst_rd = 1;
      hst_addr = ta - AW'(HALF - 1) + AW'(i);
    end
    @(negedge hst_clk);
    hst_rd = 0;
    chk(hst_data, seq[ke + HALF], "R6 R7 record last word");
    chk(hst_ready, 0, "R8 ready after drain");
  endtask

  task automatic acquire(bit rise, int l, int k, bit do_cfg, bit eq, bit do_read);
    int ke, base;
    logic [AW-1:0] ta;
    build(rise, l, k, (k % (HALF - 1)) + 1);
    if (eq) begin
      if (rise) begin seq[HALF-1] = 8'(l); seq[HALF] = 8'(l); seq[HALF+1] = 8'(l + 9); end
      else seq[k-1] = 8'(l);
    end
    ke = scan(rise, 8'(l));
    if (do_cfg) cfg(rise, 8'(l));
    base = wc;
    for (int i = 0; i < ke + HALF; i++) send(seq[i], 1);
    repeat (8) @(negedge hst_clk);
    chk(hst_ready, 0, "R5 ready before last post sample");
    send(seq[ke + HALF], 1);
    for (int i = 0; i < 3; i++) send(8'hA5, 0);
    wait_ready(1);
    chk(hst_ready, 1, "R8 ready after completion");
    ta = AW'(base + ke);
    chk(trig_addr, ta, rise ? "R2 R4 trigger address" : "R3 R4 trigger address");
    if (do_read) begin
      drain(ta, ke);
      repeat (30) @(negedge smp_clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge smp_clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int ks [5];
    int ls [4];
    ks = '{HALF, HALF + 1, HALF + 5, 2 * HALF + 3, 3 * HALF + 7};
    ls = '{1, 'h55, 'h80, 'hFF};
    repeat (4) @(negedge smp_clk);
    rst_n = 1;
    repeat (3) @(negedge hst_clk);
    chk(hst_ready, 0, "R1 ready after reset");
    chk(trig_addr, 0, "R1 trig_addr after reset");

    // R2 R3 R4 R9 sweep: first capture per setting configured, rest re-arm on drain
    for (int m = 0; m < 2; m++)
      for (int li = 0; li < 4; li++)
        for (int ki = 0; ki < 5; ki++)
          acquire(m[0], ls[li], ks[ki], ki == 0, 0, 1);

    // R2 R3 equality corner cases
    acquire(1, 'h40, HALF + 6, 1, 1, 1);
    acquire(0, 'h40, HALF + 4, 1, 1, 1);

    // R10 configuration write while a record is held
    acquire(1, 'h30, HALF + 2, 1, 0, 0);
    cfg(0, 8'h90);
    repeat (10) @(negedge hst_clk);
    chk(hst_ready, 0, "R10 held record discarded");
    repeat (10) @(negedge smp_clk);
    acquire(0, 'h90, HALF + 3, 0, 0, 1);

    // R10 configuration write in the middle of a capture
    build(1, 'h70, HALF + 1, 2);
    cfg(1, 8'h70);
    for (int i = 0; i < HALF + 4; i++) send(seq[i], 1);
    acquire(0, 'h22, HALF + 2, 1, 0, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule